// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block lets a host reach a 32-bit register space that sits behind a plain Clause 22 MDIO management bus. The host presents one request at a time: a read, a write or a masked read-modify-write, together with a byte register address. The bridge breaks the address into a page, a PHY-address offset and an even register number. It writes the page to a fixed page-select PHY address, then waits a programmable settling interval. It then moves the 32-bit word as two 16-bit MDIO accesses, low half first.

The bridge is the bus master. It generates MDC from the system clock with a programmable divider. It drives MDIO while MDC is low and releases the line during the turnaround and data phases of a read. A single-cycle done pulse returns the read word, or for a write or update the word that was written.

Top module: `mdio_paged_bridge`

## Requirements
- R1: The address bits are split as page = addr[17:9], PHY offset = addr[8:6] and register number = {addr[5:2], 0}. Bits addr[1:0] have no effect on any frame.
- R2: Each request starts with one write frame to PHY 0x18, register 0, whose data is the 9-bit page zero-extended to 16 bits. A read or write request then issues exactly 2 more frames and an update request exactly 4 more.
- R3: At least SETTLE_CYC system clock cycles pass between the last MDC rising edge of the page frame and the first MDC rising edge of the next frame.
- R4: Data frames address PHY 0x10 OR offset. The low half uses the even register number and the high half uses the register number plus 1, and the low-half frame always comes before the high-half frame.
- R5: A read (req_op = 00) returns {high half, low half} on rsp_data with rsp_done.
- R6: A write (req_op = 01) sends req_wdata[15:0] and then req_wdata[31:16], and returns req_wdata on rsp_data.
- R7: An update (req_op[1] = 1) reads both halves, then writes back (old AND NOT req_mask) OR req_wdata low half first, and returns that word.
- R8: Each frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register, turnaround (10 on write), then 16 data bits, all MSB first.
- R9: The MDC period is 2*MDC_HALF system cycles. mdio_o changes only while MDC is low. mdio_oe is low from the turnaround of a read to the end of that frame.
- R10: req_ready is high only while idle and busy is its complement. A request held valid while busy is not taken. rsp_done is a single-cycle pulse.
- R11: In reset req_ready = 1, busy = 0, rsp_done = 0, mdc = 0 and mdio_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request taken on this cycle if valid |
| req_op | input | 2 | 00 read, 01 write, 1x masked update |
| req_addr | input | 18 | Byte register address |
| req_wdata | input | 32 | Write data, or bits to set on update |
| req_mask | input | 32 | Bits to clear on update |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Read word or word written |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest part to reach from the ports is the read turnaround. During that phase the bridge must release the line, and a responding device must put the right bits on it at the right MDC edges. The bench holds a bit-level slave model. The model decodes every frame and keeps its own paged register store. It drives read data one MDC period ahead of the bridge's sampling edge. The update path and the settle window are reached by preloading the store with patterns. The bench then sweeps offsets, register numbers and pages, and measures the time between frames.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int unsigned ADDR_W     = 18;
  localparam int unsigned PAGE_W     = 9;
  localparam int unsigned OFF_W      = 3;
  localparam int unsigned REGN_W     = 5;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned WORD_W     = 2 * HALF_W;
  localparam int unsigned FRAME_BITS = 64;
  localparam logic [4:0]  PAGE_PHY   = 5'h18;
  localparam logic [4:0]  DATA_PHY   = 5'h10;

  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_SETTLE, S_RD_LO, S_RD_HI, S_WR_LO, S_WR_HI
  } seq_state_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic [REGN_W-1:0] regn;
  } reg_loc_t;

  function automatic reg_loc_t split_addr(input logic [ADDR_W-1:0] a);
    reg_loc_t l;
    l.regn = {a[5:2], 1'b0};
    l.off  = a[8:6];
    l.page = a[17:9];
    return l;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF = 25
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = ($clog2(HALF) > 0) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          term;

  assign term      = (cnt == CW'(HALF - 1));
  assign rise_tick = term & ~mdc;
  assign fall_tick = term & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              start,
  input  logic              is_read,
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [HALF_W-1:0] wdata,
  output logic              done,
  output logic [HALF_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned PRE_W    = FRAME_BITS - 32;
  localparam int unsigned CNT_W    = $clog2(FRAME_BITS + 1);
  localparam int unsigned TA_POS   = FRAME_BITS - HALF_W - 2;
  localparam int unsigned DATA_POS = FRAME_BITS - HALF_W;

  logic                  active, rd_mode;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_mode <= 1'b0;
      cnt     <= '0;
      frame   <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          rd_mode <= is_read;
          cnt     <= '0;
          frame   <= {{PRE_W{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), phy, regn,
                      (is_read ? 2'b11 : 2'b10), (is_read ? {HALF_W{1'b1}} : wdata)};
        end
      end else begin
        if (fall_tick) begin
          if (cnt == CNT_W'(FRAME_BITS)) begin
            active  <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            mdio_o  <= frame[FRAME_BITS-1];
            frame   <= {frame[FRAME_BITS-2:0], 1'b0};
            mdio_oe <= !(rd_mode && cnt >= CNT_W'(TA_POS));
            cnt     <= cnt + 1'b1;
          end
        end
        if (rise_tick && rd_mode && cnt > CNT_W'(DATA_POS))
          rdata <= {rdata[HALF_W-2:0], mdio_i};
      end
    end
  end

  // R9
  mdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode && cnt > CNT_W'(TA_POS)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int unsigned MDC_HALF   = 25,
  parameter int unsigned SETTLE_CYC = 1250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] req_mask,
  output logic              busy,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);

  seq_state_t        state;
  reg_loc_t          loc, req_loc;
  logic [1:0]        op_q;
  logic [WORD_W-1:0] wbuf, mask_q, rmw_word;
  logic [HALF_W-1:0] lo_q, eng_wd, eng_rdata;
  logic [SET_W-1:0]  set_cnt, gap_cnt;
  logic              eng_start, eng_rd, eng_done, rise_tick, fall_tick;
  logic [4:0]        eng_phy, eng_reg, data_phy;

  assign req_loc   = split_addr(req_addr);
  assign data_phy  = DATA_PHY | {2'b00, loc.off};
  assign rmw_word  = ({eng_rdata, lo_q} & ~mask_q) | wbuf;
  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);

  mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(eng_start), .is_read(eng_rd), .phy(eng_phy), .regn(eng_reg),
    .wdata(eng_wd), .done(eng_done), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      loc       <= '0;
      op_q      <= '0;
      wbuf      <= '0;
      mask_q    <= '0;
      lo_q      <= '0;
      set_cnt   <= '0;
      eng_start <= 1'b0;
      eng_rd    <= 1'b0;
      eng_phy   <= '0;
      eng_reg   <= '0;
      eng_wd    <= '0;
      rsp_done  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      eng_start <= 1'b0;
      rsp_done  <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          loc       <= req_loc;
          op_q      <= req_op;
          wbuf      <= req_wdata;
          mask_q    <= req_mask;
          eng_start <= 1'b1;
          eng_rd    <= 1'b0;
          eng_phy   <= PAGE_PHY;
          eng_reg   <= '0;
          eng_wd    <= {{(HALF_W-PAGE_W){1'b0}}, req_loc.page};
          state     <= S_PAGE;
        end
        S_PAGE: if (eng_done) begin
          set_cnt <= '0;
          state   <= S_SETTLE;
        end
        S_SETTLE: begin
          if (set_cnt == SET_W'(SETTLE_CYC - 1)) begin
            eng_start <= 1'b1;
            eng_phy   <= data_phy;
            eng_reg   <= loc.regn;
            if (op_q == 2'b01) begin
              eng_rd <= 1'b0;
              eng_wd <= wbuf[HALF_W-1:0];
              state  <= S_WR_LO;
            end else begin
              eng_rd <= 1'b1;
              state  <= S_RD_LO;
            end
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        S_RD_LO: if (eng_done) begin
          lo_q      <= eng_rdata;
          eng_start <= 1'b1;
          eng_reg   <= loc.regn | 5'd1;
          state     <= S_RD_HI;
        end
        S_RD_HI: if (eng_done) begin
          if (op_q[1]) begin
            wbuf      <= rmw_word;
            eng_start <= 1'b1;
            eng_rd    <= 1'b0;
            eng_reg   <= loc.regn;
            eng_wd    <= rmw_word[HALF_W-1:0];
            state     <= S_WR_LO;
          end else begin
            rsp_data <= {eng_rdata, lo_q};
            rsp_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_WR_LO: if (eng_done) begin
          eng_start <= 1'b1;
          eng_reg   <= loc.regn | 5'd1;
          eng_wd    <= wbuf[WORD_W-1:HALF_W];
          state     <= S_WR_HI;
        end
        S_WR_HI: if (eng_done) begin
          rsp_data <= wbuf;
          rsp_done <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker counter: cycles since the page frame finished (saturating)
  always_ff @(posedge clk) begin
    if (rst) gap_cnt <= '0;
    else if (state == S_PAGE && eng_done) gap_cnt <= '0;
    else if (gap_cnt != SET_W'(SETTLE_CYC)) gap_cnt <= gap_cnt + 1'b1;
  end

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_start && eng_phy != PAGE_PHY) |-> gap_cnt >= SET_W'(SETTLE_CYC));

  // R2
  page_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (eng_start && eng_phy == PAGE_PHY && !eng_rd));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/sim_mdio_paged_bridge.sv
`timescale 1ns/1ps
module sim_mdio_paged_bridge;
  localparam int H   = 2;
  localparam int SET = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0, req_mask = '0;
  logic        req_ready, busy, rsp_done, mdc, mdio_o, mdio_oe;
  logic [31:0] rsp_data;
  logic        s_drv = 1'b0, s_bit = 1'b1;
  wire         line = mdio_oe ? mdio_o : (s_drv ? s_bit : 1'b1);

  always #2 clk = ~clk;

  mdio_paged_bridge #(.MDC_HALF(H), .SETTLE_CYC(SET)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .busy(busy), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model: paged 16-bit store
  logic [15:0] mem [int];
  function automatic int key(int pg, int off, int rn);
    return pg * 256 + off * 32 + rn;
  endfunction
  function automatic logic [15:0] rd16(int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  int  lg_phy[8], lg_reg[8], lg_rd[8], lg_dat[8];
  time lg_t0[8], lg_t1[8];
  int  lg_n = 0, fmt_err = 0, rel_err = 0, per_err = 0;
  int  slv_page = 0, s_k = 0;
  bit  s_act = 0, s_rd = 0;
  logic [63:0] fr;
  logic [15:0] s_val;
  logic [4:0]  s_phy, s_reg;
  time t_first, t_prev;

  always @(posedge mdc) begin
    if (!s_act && mdio_oe) begin
      s_act = 1; s_k = 0; fr = '0; t_first = $time; s_rd = 0;
    end
    if (s_act) begin
      fr = {fr[62:0], line};
      if (s_k > 0 && ($time - t_prev) != 2 * H * 4) per_err++;
      t_prev = $time;
      if (s_k == 45) begin
        s_rd  = (fr[11:10] == 2'b10);
        s_phy = fr[9:5];
        s_reg = fr[4:0];
        if (fr[13:12] != 2'b01 || !(fr[11:10] == 2'b01 || fr[11:10] == 2'b10)) fmt_err++;
        if (s_rd) s_val = rd16(key(slv_page, int'(s_phy) - 16, int'(s_reg)));
      end
      if (s_rd && s_k >= 46 && mdio_oe) rel_err++;
      if (s_rd) begin
        if (s_k == 46) begin s_drv = 1; s_bit = 0; end
        else if (s_k >= 47 && s_k <= 62) s_bit = s_val[62 - s_k];
        else if (s_k == 63) s_drv = 0;
      end
      if (s_k == 63) begin
        if (fr[63:32] != 32'hFFFF_FFFF) fmt_err++;
        if (!s_rd) begin
          if (fr[17:16] != 2'b10) fmt_err++;
          if (s_phy == 5'h18 && s_reg == 0) slv_page = int'(fr[8:0]);
          else if (s_phy >= 5'h10 && s_phy <= 5'h17)
            mem[key(slv_page, int'(s_phy) - 16, int'(s_reg))] = fr[15:0];
        end
        if (lg_n < 8) begin
          lg_phy[lg_n] = int'(s_phy); lg_reg[lg_n] = int'(s_reg); lg_rd[lg_n] = int'(s_rd);
          lg_dat[lg_n] = s_rd ? int'(s_val) : int'(fr[15:0]);
          lg_t0[lg_n] = t_first; lg_t1[lg_n] = $time;
        end
        lg_n++;
        s_act = 0;
      end else s_k++;
    end
  end

  task automatic chk_frame(input int i, input int phy, input int rn, input int rd, input int dat, input string tag);
    chk(lg_phy[i] == phy && lg_reg[i] == rn && lg_rd[i] == rd, tag,
        32'(lg_phy[i] * 1024 + lg_reg[i] * 2 + lg_rd[i]), 32'(phy * 1024 + rn * 2 + rd));
    chk(lg_dat[i] == dat, tag, 32'(lg_dat[i]), 32'(dat));
  endtask

  task automatic do_req(input logic [1:0] op, input logic [17:0] addr,
                        input logic [31:0] wd, input logic [31:0] mk);
    int pg, off, rn, dphy;
    logic [31:0] old, expw, got;
    pg = int'(addr[17:9]); off = int'(addr[8:6]); rn = int'({addr[5:2], 1'b0});
    dphy = 16 + off;
    old  = {rd16(key(pg, off, rn + 1)), rd16(key(pg, off, rn))};
    expw = op[1] ? ((old & ~mk) | wd) : wd;
    lg_n = 0; fmt_err = 0; rel_err = 0; per_err = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
    @(negedge clk);
    chk(busy && !req_ready, "R10 busy after accept", {30'd0, busy, req_ready}, 32'd2);
    // stray request held while busy: must not be taken (R10)
    req_op = 2'b01; req_addr = {9'h0AA, 3'd7, 4'd15, 2'b00}; req_wdata = 32'hDEAD_BEEF;
    while (!rsp_done) @(negedge clk);
    req_valid = 0;
    got = rsp_data;
    @(negedge clk);
    chk(!rsp_done && req_ready, "R10 done pulse", {30'd0, rsp_done, req_ready}, 32'd1);
    chk(!mem.exists(key(9'h0AA, 7, 30)), "R10 stray request ignored", 32'(mem.exists(key(9'h0AA, 7, 30))), 32'd0);
    chk(lg_n == (op[1] ? 5 : 3), "R2 frame count", 32'(lg_n), op[1] ? 32'd5 : 32'd3);
    chk_frame(0, 24, 0, 0, pg, "R2 R1 page frame");
    chk((lg_t0[1] - lg_t1[0]) >= SET * 4, "R3 settle gap", 32'(lg_t0[1] - lg_t1[0]), 32'(SET * 4));
    chk(fmt_err == 0, "R8 frame format", 32'(fmt_err), 32'd0);
    chk(rel_err == 0 && per_err == 0, "R9 release and MDC period", 32'(rel_err * 256 + per_err), 32'd0);
    if (op == 2'b00) begin
      chk_frame(1, dphy, rn, 1, int'(old[15:0]), "R4 R1 read low");
      chk_frame(2, dphy, rn + 1, 1, int'(old[31:16]), "R4 read high");
      chk(got == old, "R5 read word", got, old);
    end else if (op == 2'b01) begin
      chk_frame(1, dphy, rn, 0, int'(wd[15:0]), "R6 R4 write low");
      chk_frame(2, dphy, rn + 1, 0, int'(wd[31:16]), "R6 write high");
      chk(got == wd, "R6 response", got, wd);
    end else begin
      chk_frame(1, dphy, rn, 1, int'(old[15:0]), "R7 read low");
      chk_frame(2, dphy, rn + 1, 1, int'(old[31:16]), "R7 read high");
      chk_frame(3, dphy, rn, 0, int'(expw[15:0]), "R7 write low");
      chk_frame(4, dphy, rn + 1, 0, int'(expw[31:16]), "R7 write high");
      chk(got == expw, "R7 response", got, expw);
    end
    if (op != 2'b00)
      chk({rd16(key(pg, off, rn + 1)), rd16(key(pg, off, rn))} == expw, "R6 R7 stored word",
          {rd16(key(pg, off, rn + 1)), rd16(key(pg, off, rn))}, expw);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 8; o++)
        for (int r = 0; r < 32; r++)
          mem[key(p * 9'h155, o, r)] = 16'((p * 40503 + o * 4099 + r * 263 + 17) ^ (r << 9));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !busy && !rsp_done && !mdc && !mdio_oe, "R11 reset state",
        {27'd0, req_ready, busy, rsp_done, mdc, mdio_oe}, 32'h10);
    rst = 0;
    // reads over offsets and register numbers on two pages
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 8; o++)
        for (int r = 0; r < 3; r++)
          do_req(2'b00, {9'(p * 9'h155), 3'(o), 4'(r * 7), 2'(o)}, 32'h0, 32'h0);
    // writes, low address bits varied (R1)
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 8; o++)
        do_req(2'b01, {(p == 0) ? 9'h001 : 9'h1FF, 3'(o), 4'(3 + o), 2'(3 - o % 4)},
               32'(32'h1357_9BDF ^ (o * 32'h0101_0101) ^ (p << 31)), 32'h0);
    // read back a written word with different low address bits (R1)
    do_req(2'b00, {9'h1FF, 3'd5, 4'd8, 2'b00}, 32'h0, 32'h0);
    // masked updates
    for (int o = 0; o < 8; o++)
      do_req({1'b1, o[0]}, {9'h155, 3'(o), 4'(o * 2), 2'b00},
             32'(32'h00F0_0F01 << o), 32'(32'hFF00_FF0F >> o));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule